// File: doc/BRIEF.md
# Scanline-Counting Bank Switch Controller

This block sits between a CPU write port and a picture-processor bus. The CPU programs a small set of registers by writing to decoded addresses, and the block maps four 8 KB program windows and eight 1 KB pattern windows onto bank numbers. It also selects horizontal or vertical nametable mirroring. A down-counter is stepped on each qualified rising edge of pattern address line A12, and it raises a level interrupt when it reaches zero with interrupts enabled. The block is used as one personality of a multi-mode cartridge controller. The `mode` input selects it when `mode == 2'b01`.

Writes are single-cycle strobes and are accepted on every cycle that `wr_en` is high. There is no back-pressure, and a write never stalls. All bank and mirroring outputs are combinational functions of registered state, so they change on the clock edge that takes the write. A12 is sampled on the same clock, which is assumed to be the picture-processor clock.

Top module: `scanline_bank_ctrl`

## Requirements
- R1: A write counts only when `wr_en` is high, `mode == 2'b01` and `wr_addr[15]` is 1. It is decoded on `wr_addr & 16'hE001`. The keys are: 16'h8000 writes the control byte (bits [2:0] select a data register, bit 6 is the program swap, bit 7 is the pattern swap); 16'h8001 writes data register number control[2:0]; 16'hA000 writes mirroring; 16'hC000 writes the reload value; 16'hC001 sets reload-pending; 16'hE000 is acknowledge; 16'hE001 is enable. Every other address changes no state.
- R2: Program slot 0 carries register 6 when control bit 6 is 0, and 8'hFE when it is 1. Slot 2 carries the other of the two. Slot 1 carries register 7, and slot 3 is always 8'hFF. Slot i occupies `prg_bank[8*i +: 8]`.
- R3: Before swapping, pattern window 0 is register 0 with bit 0 cleared and window 1 is register 0 with bit 0 set. Windows 2 and 3 are built the same way from register 1. Windows 4 to 7 are registers 2 to 5. When control bit 7 is 1, output window i shows unswapped window i XOR 4. Window i occupies `chr_bank[8*i +: 8]`.
- R4: On a counted A12 rise, the counter loads the reload value if it is zero or reload-pending is set; otherwise it decrements by one. Reload-pending is cleared on every counted rise.
- R5: `irq` goes high after a counted rise only if the updated counter value is zero and interrupts are enabled at that time.
- R6: An acknowledge write disables interrupts and drives `irq` low on the next cycle.
- R7: Once high, `irq` stays high until an acknowledge write, including through further counted rises.
- R8: A12 rises are counted only while `mode == 2'b01`.
- R9: A rise counts only if A12 was sampled low on at least A12_MIN_LOW (default 3) consecutive clocks just before the clock on which it is sampled high. Shorter low pulses are ignored.
- R10: `mirror_horiz` follows bit 0 of the mirroring register: 1 means horizontal, 0 means vertical.
- R11: After reset, registers 0 to 7 hold 0, 2, 4, 5, 6, 7, 8'hFC and 8'hFD, and the control byte is zero. The counter, reload value, enable, reload-pending, mirroring and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also used to sample A12 |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Personality select; 2'b01 enables this controller |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| a12 | input | 1 | Pattern address line A12 |
| prg_bank | output | 32 | Four 8-bit program bank numbers |
| chr_bank | output | 64 | Eight 8-bit pattern bank numbers |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irq | output | 1 | Level interrupt request |

## Verification
A data or control register that holds the wrong value shows up on `prg_bank` or `chr_bank` on the cycle after the write, because the mapping has no register stage. Counter, reload-pending and enable faults are hidden until a later A12 rise. They appear as `irq` rising one qualified rise early or late, or not at all, so the scenarios count rises one by one against a known reload value. Filter and mode-gating faults appear the same way: an extra or missing step moves the `irq` edge by exactly one pulse.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int NUM_REGS = 8;
  localparam logic [15:0] ADDR_MASK = 16'hE001;
  localparam logic [15:0] KEY_CTRL  = 16'h8000;
  localparam logic [15:0] KEY_DATA  = 16'h8001;
  localparam logic [15:0] KEY_MIRR  = 16'hA000;
  localparam logic [15:0] KEY_RVAL  = 16'hC000;
  localparam logic [15:0] KEY_RLD   = 16'hC001;
  localparam logic [15:0] KEY_ACK   = 16'hE000;
  localparam logic [15:0] KEY_EN    = 16'hE001;

  typedef enum logic [2:0] {
    WK_NONE, WK_CTRL, WK_DATA, WK_MIRR, WK_RVAL, WK_RLD, WK_ACK, WK_EN
  } wr_kind_e;

  function automatic wr_kind_e classify(input logic [15:0] addr);
    case (addr & ADDR_MASK)
      KEY_CTRL: return WK_CTRL;
      KEY_DATA: return WK_DATA;
      KEY_MIRR: return WK_MIRR;
      KEY_RVAL: return WK_RVAL;
      KEY_RLD:  return WK_RLD;
      KEY_ACK:  return WK_ACK;
      KEY_EN:   return WK_EN;
      default:  return WK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sbc_reg_decode.sv
module sbc_reg_decode
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] bank_q [NUM_REGS],
  output logic              prg_swap,
  output logic              chr_swap,
  output logic              mirror_h,
  output logic [DATA_W-1:0] reload_val,
  output logic              reload_set,
  output logic              irq_ack,
  output logic              irq_en_set
);
  localparam int SEL_W = $clog2(NUM_REGS);

  wr_kind_e          kind;
  logic [SEL_W-1:0]  sel_q;

  always_comb begin
    kind = WK_NONE;
    if (wr_en && active && wr_addr[15]) kind = classify(wr_addr);
  end

  assign reload_set = (kind == WK_RLD);
  assign irq_ack    = (kind == WK_ACK);
  assign irq_en_set = (kind == WK_EN);

  function automatic logic [DATA_W-1:0] init_val(input int idx);
    if (idx == 0)      return '0;
    if (idx == 1)      return DATA_W'(2);
    if (idx < 6)       return DATA_W'(idx + 2);
    if (idx == 6)      return ~DATA_W'(3);
    return ~DATA_W'(2);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= '0;
      prg_swap   <= 1'b0;
      chr_swap   <= 1'b0;
      mirror_h   <= 1'b0;
      reload_val <= '0;
    end else begin
      case (kind)
        WK_CTRL: begin
          sel_q    <= wr_data[SEL_W-1:0];
          prg_swap <= wr_data[6];
          chr_swap <= wr_data[7];
        end
        WK_MIRR: mirror_h   <= wr_data[0];
        WK_RVAL: reload_val <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  bank_q[g] <= init_val(g);
      else if (kind == WK_DATA && sel_q == SEL_W'(g)) bank_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/sbc_a12_filter.sv
module sbc_a12_filter #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12,
  output logic rise
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW);

  logic          a12_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a12_q   <= 1'b0;
      low_cnt <= '0;
    end else begin
      a12_q <= a12;
      if (a12)                low_cnt <= '0;
      else if (low_cnt < SAT) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign rise = a12 && !a12_q && (low_cnt >= SAT);
endmodule

// File: rtl/sbc_irq_unit.sv
module sbc_irq_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              reload_set,
  input  logic              irq_ack,
  input  logic              irq_en_set,
  output logic              irq_en,
  output logic              reload_pend,
  output logic              irq
);
  logic [DATA_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (cnt_q == '0 || reload_pend) cnt_nx = reload_val;
    else                            cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      irq_en      <= 1'b0;
      reload_pend <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (tick) begin
        cnt_q <= cnt_nx;
        if (cnt_nx == '0 && irq_en) irq <= 1'b1;
      end
      if (reload_set)  reload_pend <= 1'b1;
      else if (tick)   reload_pend <= 1'b0;
      if (irq_ack) begin
        irq_en <= 1'b0;
        irq    <= 1'b0;
      end else if (irq_en_set) begin
        irq_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbc_bank_map.sv
module sbc_bank_map
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   bank_q [NUM_REGS],
  input  logic                prg_swap,
  input  logic                chr_swap,
  output logic [4*DATA_W-1:0] prg_flat,
  output logic [8*DATA_W-1:0] chr_flat
);
  localparam logic [DATA_W-1:0] LAST   = '1;
  localparam logic [DATA_W-1:0] SECOND = ~DATA_W'(1);

  logic [DATA_W-1:0] base [8];

  assign prg_flat[0*DATA_W +: DATA_W] = prg_swap ? SECOND : bank_q[6];
  assign prg_flat[1*DATA_W +: DATA_W] = bank_q[7];
  assign prg_flat[2*DATA_W +: DATA_W] = prg_swap ? bank_q[6] : SECOND;
  assign prg_flat[3*DATA_W +: DATA_W] = LAST;

  for (genvar w = 0; w < 8; w++) begin : g_win
    if (w < 4) begin : g_pair
      assign base[w] = {bank_q[w/2][DATA_W-1:1], 1'(w % 2)};
    end else begin : g_single
      assign base[w] = bank_q[w-2];
    end
    localparam logic [2:0] WI = 3'(w);
    assign chr_flat[w*DATA_W +: DATA_W] = base[WI ^ {chr_swap, 2'b00}];
  end
endmodule

// File: rtl/scanline_bank_ctrl.sv
module scanline_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int A12_MIN_LOW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                wr_en,
  input  logic [15:0]         wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                a12,
  output logic [4*DATA_W-1:0] prg_bank,
  output logic [8*DATA_W-1:0] chr_bank,
  output logic                mirror_horiz,
  output logic                irq
);
  logic              active;
  logic [DATA_W-1:0] bank_q [NUM_REGS];
  logic              prg_swap, chr_swap;
  logic [DATA_W-1:0] reload_val;
  logic              reload_set, irq_ack, irq_en_set;
  logic              a12_rise, tick;
  logic              irq_en, reload_pend;

  assign active = (mode == 2'b01);
  assign tick   = a12_rise && active;

  sbc_reg_decode #(.DATA_W(DATA_W)) u_dec (
    .clk, .rst_n, .active, .wr_en, .wr_addr, .wr_data,
    .bank_q, .prg_swap, .chr_swap, .mirror_h(mirror_horiz),
    .reload_val, .reload_set, .irq_ack, .irq_en_set
  );

  sbc_a12_filter #(.MIN_LOW(A12_MIN_LOW)) u_flt (
    .clk, .rst_n, .a12, .rise(a12_rise)
  );

  sbc_irq_unit #(.DATA_W(DATA_W)) u_irq (
    .clk, .rst_n, .tick, .reload_val, .reload_set, .irq_ack, .irq_en_set,
    .irq_en, .reload_pend, .irq
  );

  sbc_bank_map #(.DATA_W(DATA_W)) u_map (
    .bank_q, .prg_swap, .chr_swap, .prg_flat(prg_bank), .chr_flat(chr_bank)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic                wr_en,
  input logic [15:0]         wr_addr,
  input logic                a12,
  input logic                irq,
  input logic                irq_en,
  input logic                reload_pend,
  input logic                tick,
  input logic [8*DATA_W-1:0] chr_bank
);
  logic on, ack_wr, rld_wr, pair_ok;
  assign on     = wr_en && (mode == 2'b01) && wr_addr[15];
  assign ack_wr = on && ((wr_addr & 16'hE001) == 16'hE000);
  assign rld_wr = on && ((wr_addr & 16'hE001) == 16'hC001);
  assign pair_ok = ((chr_bank[0 +: DATA_W] | DATA_W'(1)) == chr_bank[DATA_W +: DATA_W])
                || ((chr_bank[4*DATA_W +: DATA_W] | DATA_W'(1)) == chr_bank[5*DATA_W +: DATA_W]);

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> !irq); // R6
  AST_IRQ_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> irq); // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en)); // R5
  AST_IRQ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(mode) == 2'b01)); // R8
  AST_IRQ_ON_A12_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(a12)); // R9
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rld_wr) |=> !reload_pend); // R4
  AST_CHR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ok); // R3
endmodule

bind scanline_bank_ctrl sbc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk, .rst_n, .mode, .wr_en, .wr_addr, .a12, .irq,
  .irq_en, .reload_pend, .tick, .chr_bank
);

// File: tb/sim_scanline_bank_ctrl.sv
`timescale 1ns/1ps
module sim_scanline_bank_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  mode = 2'b01;
  logic        wr_en = 0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        a12 = 0;
  logic [31:0] prg_bank;
  logic [63:0] chr_bank;
  logic        mirror_horiz, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scanline_bank_ctrl u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int prg(input int i); return int'(prg_bank[8*i +: 8]); endfunction
  function automatic int chr(input int i); return int'(chr_bank[8*i +: 8]); endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input int low);
    @(negedge clk); a12 = 0;
    repeat (low) @(posedge clk);
    @(negedge clk); a12 = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 prg0", prg(0), 'hFC); chk("R11 prg1", prg(1), 'hFD);
    chk("R11 prg2", prg(2), 'hFE); chk("R11 prg3", prg(3), 'hFF);
    for (int i = 0; i < 8; i++) chk("R11 chr", chr(i), i);
    chk("R11 irq", irq, 0); chk("R11 mirror", mirror_horiz, 0);
  endtask

  task automatic t_prg;
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h10);
    chk("R2 slot0 normal", prg(0), 'h10); chk("R2 slot2 normal", prg(2), 'hFE);
    wr(16'h8000, 8'h46);
    chk("R2 slot0 swapped", prg(0), 'hFE); chk("R2 slot2 swapped", prg(2), 'h10);
    chk("R2 slot3 fixed", prg(3), 'hFF);
    wr(16'h9FFE, 8'h07);
    chk("R1 alias ctrl", prg(0), 'h10);
    wr(16'h8003, 8'h33);
    chk("R1 alias data", prg(1), 'h33);
    wr(16'h7001, 8'h55);
    chk("R1 low addr ignored", prg(1), 'h33);
    wr(16'hA001, 8'h01);
    chk("R1 unmapped ignored", mirror_horiz, 0);
  endtask

  task automatic t_chr;
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h21);
    chk("R3 even win", chr(0), 'h20); chk("R3 odd win", chr(1), 'h21);
    wr(16'h8000, 8'h85); wr(16'h8001, 8'h99);
    chk("R3 swap r5", chr(3), 'h99); chk("R3 swap w4", chr(4), 'h20);
    chk("R3 swap w5", chr(5), 'h21); chk("R3 swap w0", chr(0), 4);
    wr(16'h8000, 8'h00);
    chk("R3 unswap r5", chr(7), 'h99);
  endtask

  task automatic t_mirror;
    wr(16'hA000, 8'h01); chk("R10 horiz", mirror_horiz, 1);
    wr(16'hA002, 8'hFE); chk("R10 vert", mirror_horiz, 0);
  endtask

  task automatic t_irq_count;
    wr(16'hC000, 8'd3); wr(16'hC001, 0); wr(16'hE001, 0);
    pulse(4); pulse(4); pulse(4);
    chk("R4 three rises no irq", irq, 0);
    pulse(4);
    chk("R5 irq at zero", irq, 1);
    pulse(4);
    repeat (5) @(negedge clk);
    chk("R7 irq held", irq, 1);
    wr(16'hE000, 0);
    chk("R6 ack clears", irq, 0);
  endtask

  task automatic t_irq_disabled;
    pulse(4); pulse(4); pulse(4);
    chk("R5 disabled no irq", irq, 0);
  endtask

  task automatic t_filter;
    wr(16'hC000, 8'd1); wr(16'hC001, 0); wr(16'hE001, 0);
    pulse(4);
    chk("R9 load one", irq, 0);
    pulse(1); pulse(2);
    chk("R9 short lows ignored", irq, 0);
    pulse(3);
    chk("R9 min low counts", irq, 1);
    wr(16'hE000, 0);
  endtask

  task automatic t_mode;
    wr(16'hC000, 8'd1); wr(16'hC001, 0); wr(16'hE001, 0);
    @(negedge clk); mode = 2'b00;
    pulse(4);
    wr(16'hA000, 8'h01);
    chk("R1 write ignored off-mode", mirror_horiz, 0);
    @(negedge clk); mode = 2'b01;
    pulse(4);
    chk("R8 off-mode rise ignored", irq, 0);
    pulse(4);
    chk("R8 counting resumes", irq, 1);
    wr(16'hE000, 0);
    chk("R6 ack again", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prg();
    t_chr();
    t_mirror();
    t_irq_count();
    t_irq_disabled();
    t_filter();
    t_mode();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule